// File: doc/BRIEF.md
# Frame Writeback DMA Controller

This block captures a single frame of 32-bit pixels from a compositor output stream and stores it in memory as a raster image. Software programs a small register bank over a simple 32-bit register bus: the base address of the image, the byte pitch between lines, the frame dimensions and a control word. Setting the start bit launches a capture. From then on, every pixel beat that the stream offers is turned into one memory write request. The request carries an address, the pixel word and byte strobes, and it completes with a ready handshake.

Line n of the image begins at the base address plus n times the pitch, and the beats within a line step by 4 bytes. A progress register counts the lines whose final beat memory has accepted. A busy flag shows whether a capture is running. When the engine is idle and the interrupt-enable bit is set, the interrupt line is high. Software clears that enable bit to acknowledge. An abort command ends a capture at once. A power-down bit blocks new starts. An optional mode asks the compositor for the next frame when the current one completes.

Top module: `wb_frame_dma`

## Requirements
- R1: After reset, the control register (offset 0x0C) reads 0x5440_0000. That value has 0x54 in bits 31:24, 0x1 in bits 23:22 and all other bits 0. The progress register (offset 0x10) reads 0, no memory request is issued, and `irq` and `frame_req` are low.
- R2: The pointer register (0x00) reads back with bits 1:0 forced to zero. The pitch register (0x04) reads back with bits 3:0 forced to zero. The dimension register (0x08) holds the height in bits 31:16 and the width in bits 15:0, both counted in 32-bit beats and lines.
- R3: Writing the control register with bit 0 (start) set, while idle, starts a frame. Busy (control bit 1) reads 1 from the next cycle. Bit 0 always reads 0.
- R4: A start is ignored when busy is already set, when the same write sets bit 21 (power-down), or when the stored width or height is zero. In all three cases busy, progress and the beat position are left unchanged.
- R5: A request for beat k of line n has address base + n*pitch + 4*k. Its data equals `pix_data`, and its strobes equal control bits 19:16.
- R6: Progress resets to 0 on an accepted start. It rises by exactly 1 in the cycle after memory accepts the last beat of a line, and never changes otherwise.
- R7: When memory accepts the last beat of the last line, busy reads 0 from the next cycle and progress equals the height.
- R8: A control write with bit 14 (abort) while busy blocks memory requests from that same cycle. Busy drops on the next cycle, and progress keeps the number of lines already completed.
- R9: `irq` is high exactly when control bit 2 (interrupt enable) is set and busy is clear. Writing bit 2 as 0 lowers `irq` from the next cycle.
- R10: `frame_req` pulses for one cycle after every accepted start. It also pulses one cycle after a normal frame completion when control bit 15 is set. There is no pulse after an abort.
- R11: `mem_valid` is asserted only while busy and `pix_valid` is high. `pix_ready` equals busy and `mem_ready`, both gated by an abort write. A stalled request keeps its address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 5 | Register byte offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| pix_valid | input | 1 | Pixel beat offered |
| pix_data | input | 32 | Pixel beat |
| pix_ready | output | 1 | Pixel beat taken |
| mem_valid | output | 1 | Memory write request |
| mem_addr | output | 32 | Write byte address |
| mem_wdata | output | 32 | Write data |
| mem_strb | output | 4 | Byte strobes |
| mem_ready | input | 1 | Memory accepts the request |
| frame_req | output | 1 | Frame-start request pulse to the compositor |
| irq | output | 1 | Idle interrupt |

## Verification
The hardest situation to reach is an abort that arrives in the same cycle as a beat that would otherwise have been accepted, partway through a line. It must leave progress at the last fully committed line. The bench drives an uninterrupted stream with memory always ready, so the beat count at the abort is known exactly. It then writes the abort while a beat is still offered. Random valid and ready gaps in the other frames make stalled requests and line wraps happen on many different cycles.

// File: rtl/wb_pkg.sv
package wb_pkg;
  localparam int REG_W = 32;
  localparam int OFS_W = 5;

  localparam logic [OFS_W-1:0] OFS_PTR   = 5'h00;
  localparam logic [OFS_W-1:0] OFS_PITCH = 5'h04;
  localparam logic [OFS_W-1:0] OFS_DIM   = 5'h08;
  localparam logic [OFS_W-1:0] OFS_CTRL  = 5'h0C;
  localparam logic [OFS_W-1:0] OFS_PROG  = 5'h10;

  localparam int B_GO     = 0;
  localparam int B_BUSY   = 1;
  localparam int B_IE     = 2;
  localparam int B_ABORT  = 14;
  localparam int B_REQEOF = 15;
  localparam int B_STRB   = 16;
  localparam int B_PD     = 21;

  localparam logic [7:0] ID_TAG = 8'h54;
  localparam logic [1:0] ID_REV = 2'b01;

  typedef struct packed {
    logic       pd;
    logic [3:0] strb;
    logic       reqeof;
    logic       ie;
  } ctrl_t;
endpackage

// File: rtl/wb_regfile.sv
module wb_regfile
  import wb_pkg::*;
#(
  parameter int DIM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OFS_W-1:0] reg_addr,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             busy_i,
  input  logic [DIM_W-1:0] lines_i,
  output logic [REG_W-1:0] ptr_o,
  output logic [REG_W-1:0] pitch_o,
  output logic [DIM_W-1:0] width_o,
  output logic [DIM_W-1:0] height_o,
  output logic             ie_o,
  output logic             reqeof_o,
  output logic [3:0]       strb_o,
  output logic             go_wr_o,
  output logic             abort_wr_o
);
  localparam int PTR_LSB   = 2;
  localparam int PITCH_LSB = 4;
  localparam int HGT_LSB   = 16;

  logic [REG_W-1:0] ptr_q, pitch_q;
  logic [DIM_W-1:0] wid_q, hgt_q;
  ctrl_t            ctrl_q, ctrl_d;
  logic             ptr_en, pitch_en, dim_en, ctrl_en;

  assign ptr_en   = reg_we && (reg_addr == OFS_PTR);
  assign pitch_en = reg_we && (reg_addr == OFS_PITCH);
  assign dim_en   = reg_we && (reg_addr == OFS_DIM);
  assign ctrl_en  = reg_we && (reg_addr == OFS_CTRL);

  assign go_wr_o    = ctrl_en && reg_wdata[B_GO];
  assign abort_wr_o = ctrl_en && reg_wdata[B_ABORT];

  always_comb begin
    ctrl_d.pd     = reg_wdata[B_PD];
    ctrl_d.strb   = reg_wdata[B_STRB +: 4];
    ctrl_d.reqeof = reg_wdata[B_REQEOF];
    ctrl_d.ie     = reg_wdata[B_IE];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= {reg_wdata[REG_W-1:PTR_LSB], {PTR_LSB{1'b0}}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pitch_q <= '0;
    end else if (pitch_en) begin
      pitch_q <= {reg_wdata[REG_W-1:PITCH_LSB], {PITCH_LSB{1'b0}}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wid_q <= '0;
      hgt_q <= '0;
    end else if (dim_en) begin
      wid_q <= reg_wdata[0 +: DIM_W];
      hgt_q <= reg_wdata[HGT_LSB +: DIM_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      OFS_PTR:   reg_rdata = ptr_q;
      OFS_PITCH: reg_rdata = pitch_q;
      OFS_DIM: begin
        reg_rdata[0 +: DIM_W]       = wid_q;
        reg_rdata[HGT_LSB +: DIM_W] = hgt_q;
      end
      OFS_CTRL: begin
        reg_rdata[31:24]        = ID_TAG;
        reg_rdata[23:22]        = ID_REV;
        reg_rdata[B_PD]         = ctrl_q.pd;
        reg_rdata[B_STRB +: 4]  = ctrl_q.strb;
        reg_rdata[B_REQEOF]     = ctrl_q.reqeof;
        reg_rdata[B_IE]         = ctrl_q.ie;
        reg_rdata[B_BUSY]       = busy_i;
      end
      OFS_PROG:  reg_rdata = REG_W'(lines_i);
      default:   reg_rdata = '0;
    endcase
  end

  assign ptr_o    = ptr_q;
  assign pitch_o  = pitch_q;
  assign width_o  = wid_q;
  assign height_o = hgt_q;
  assign ie_o     = ctrl_q.ie;
  assign reqeof_o = ctrl_q.reqeof;
  assign strb_o   = ctrl_q.strb;
endmodule

// File: rtl/wb_addrgen.sv
module wb_addrgen
  import wb_pkg::*;
#(
  parameter int DIM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             fire_i,
  input  logic [REG_W-1:0] ptr_i,
  input  logic [REG_W-1:0] pitch_i,
  input  logic [DIM_W-1:0] width_i,
  input  logic [DIM_W-1:0] height_i,
  output logic [REG_W-1:0] addr_o,
  output logic [DIM_W-1:0] lines_o,
  output logic             line_end_o,
  output logic             frame_end_o
);
  localparam int CW       = DIM_W + 1;
  localparam int BEAT_SHL = 2;

  logic [DIM_W-1:0] x_q, x_d, y_q, y_d;
  logic [REG_W-1:0] base_q, base_d;
  logic [CW-1:0]    x_inc, y_inc;
  logic             step_en;

  assign x_inc       = {1'b0, x_q} + CW'(1);
  assign y_inc       = {1'b0, y_q} + CW'(1);
  assign line_end_o  = (x_inc == {1'b0, width_i});
  assign frame_end_o = line_end_o && (y_inc == {1'b0, height_i});
  assign step_en     = start_i || fire_i;

  always_comb begin
    x_d    = x_q;
    y_d    = y_q;
    base_d = base_q;
    if (start_i) begin
      x_d    = '0;
      y_d    = '0;
      base_d = ptr_i;
    end else if (fire_i) begin
      if (line_end_o) begin
        x_d    = '0;
        y_d    = y_q + 1'b1;
        base_d = base_q + pitch_i;
      end else begin
        x_d = x_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q    <= '0;
      y_q    <= '0;
      base_q <= '0;
    end else if (step_en) begin
      x_q    <= x_d;
      y_q    <= y_d;
      base_q <= base_d;
    end
  end

  assign addr_o  = base_q + (REG_W'(x_q) << BEAT_SHL);
  assign lines_o = y_q;

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && !start_i && !line_end_o) |=> (addr_o == $past(addr_o) + 32'd4)) else $error("addr step"); // R5

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire_i && !start_i) |=> $stable(addr_o)) else $error("addr hold"); // R11
endmodule

// File: rtl/wb_frame_dma.sv
module wb_frame_dma
  import wb_pkg::*;
#(
  parameter int DIM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OFS_W-1:0] reg_addr,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             pix_valid,
  input  logic [REG_W-1:0] pix_data,
  output logic             pix_ready,
  output logic             mem_valid,
  output logic [REG_W-1:0] mem_addr,
  output logic [REG_W-1:0] mem_wdata,
  output logic [3:0]       mem_strb,
  input  logic             mem_ready,
  output logic             frame_req,
  output logic             irq
);
  // Reset synchronizer: assertion is asynchronous, release follows two flops.
  logic [1:0] rs_q;
  logic       rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ns = rs_q[1];

  logic [REG_W-1:0] ptr, pitch;
  logic [DIM_W-1:0] width, height, lines;
  logic             ie, reqeof, go_wr, abort_wr;
  logic [3:0]       strb;
  logic             line_end, frame_end;
  logic             busy_q, busy_d, freq_q, freq_d;
  logic             start, abort_now, fire, done;

  wb_regfile #(.DIM_W(DIM_W)) u_regs (
    .clk(clk), .rst_n(rst_ns),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy_i(busy_q), .lines_i(lines),
    .ptr_o(ptr), .pitch_o(pitch), .width_o(width), .height_o(height),
    .ie_o(ie), .reqeof_o(reqeof), .strb_o(strb),
    .go_wr_o(go_wr), .abort_wr_o(abort_wr)
  );

  assign start     = go_wr && !busy_q && !reg_wdata[B_PD] && (|width) && (|height);
  assign abort_now = abort_wr && busy_q;
  assign mem_valid = busy_q && pix_valid && !abort_wr;
  assign pix_ready = busy_q && mem_ready && !abort_wr;
  assign fire      = mem_valid && mem_ready;
  assign done      = fire && frame_end;

  wb_addrgen #(.DIM_W(DIM_W)) u_agen (
    .clk(clk), .rst_n(rst_ns),
    .start_i(start), .fire_i(fire),
    .ptr_i(ptr), .pitch_i(pitch), .width_i(width), .height_i(height),
    .addr_o(mem_addr), .lines_o(lines),
    .line_end_o(line_end), .frame_end_o(frame_end)
  );

  always_comb begin
    busy_d = busy_q;
    if (start)                  busy_d = 1'b1;
    else if (abort_now || done) busy_d = 1'b0;
    freq_d = start || (done && reqeof);
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      busy_q <= 1'b0;
      freq_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      freq_q <= freq_d;
    end
  end

  assign mem_wdata = pix_data;
  assign mem_strb  = strb;
  assign frame_req = freq_q;
  assign irq       = ie && !busy_q;

  logic unused_le;
  assign unused_le = line_end;

  AST_START_FROM_GO: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(busy_q) |-> $past(go_wr)) else $error("busy without start"); // R3

  AST_PROG_STEP: assert property (@(posedge clk) disable iff (!rst_ns)
    (busy_q && !start) |=> (lines == $past(lines) || lines == DIM_W'($past(lines) + 1'b1))) else $error("progress jump"); // R6

  AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_ns)
    $fell(busy_q) |-> ($past(abort_now) || lines == height)) else $error("early idle"); // R7

  AST_NO_FRAME_REQ_ON_ABORT: assert property (@(posedge clk) disable iff (!rst_ns)
    abort_now |=> !frame_req) else $error("request after abort"); // R10
endmodule

// File: tb/sim_wb_frame_dma.sv
module sim_wb_frame_dma;
  logic        clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic [4:0]  reg_addr;
  logic        reg_we;
  logic [31:0] reg_wdata, reg_rdata;
  logic        pix_valid, pix_ready;
  logic [31:0] pix_data;
  logic        mem_valid, mem_ready;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_strb;
  logic        frame_req, irq;

  wb_frame_dma u0 (
    .clk(clk), .rst_n(rst_n),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_strb(mem_strb), .mem_ready(mem_ready),
    .frame_req(frame_req), .irq(irq)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit cmp_en = 0;

  // Reference model state
  bit          m_busy, m_ie, m_pd, m_vs, m_freq;
  int          m_prog, m_x, m_w, m_h;
  logic [31:0] m_ptr, m_pitch;
  logic [3:0]  m_strb;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin : model
    bit wc, abort_now, fire, go_ok;
    if (!rst_n) begin
      m_busy = 0; m_ie = 0; m_pd = 0; m_vs = 0; m_freq = 0;
      m_prog = 0; m_x = 0; m_w = 0; m_h = 0;
      m_ptr = '0; m_pitch = '0; m_strb = '0;
    end else begin
      wc        = reg_we && reg_addr == 5'h0C;
      abort_now = wc && reg_wdata[14] && m_busy;
      fire      = m_busy && pix_valid && !(wc && reg_wdata[14]) && mem_ready;
      go_ok     = wc && reg_wdata[0] && !m_busy && !reg_wdata[21] && m_w != 0 && m_h != 0;
      m_freq = 0;
      if (go_ok) begin
        m_busy = 1; m_prog = 0; m_x = 0; m_freq = 1;
      end else if (abort_now) begin
        m_busy = 0;
      end else if (fire) begin
        m_x++;
        if (m_x == m_w) begin
          m_x = 0;
          m_prog++;
          if (m_prog == m_h) begin
            m_busy = 0;
            m_freq = m_vs;
          end
        end
      end
      if (reg_we) begin
        case (reg_addr)
          5'h00: m_ptr = reg_wdata & ~32'h3;
          5'h04: m_pitch = reg_wdata & ~32'hF;
          5'h08: begin m_h = int'(reg_wdata[31:16]); m_w = int'(reg_wdata[15:0]); end
          5'h0C: begin
            m_ie = reg_wdata[2]; m_pd = reg_wdata[21];
            m_vs = reg_wdata[15]; m_strb = reg_wdata[19:16];
          end
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin : compare
    bit ab, ev, er;
    logic [31:0] ea;
    if (cmp_en) begin
      ab = reg_we && reg_addr == 5'h0C && reg_wdata[14];
      ev = m_busy && pix_valid && !ab;
      er = m_busy && mem_ready && !ab;
      ea = m_ptr + 32'(m_prog) * m_pitch + 32'(4 * m_x);
      chk(mem_valid == ev, "R11 mem_valid", 32'(mem_valid), 32'(ev));
      chk(pix_ready == er, "R11 pix_ready", 32'(pix_ready), 32'(er));
      if (ev) begin
        chk(mem_addr == ea, "R5 mem_addr", mem_addr, ea);
        chk(mem_wdata == pix_data, "R5 mem_wdata", mem_wdata, pix_data);
        chk(mem_strb == m_strb, "R5 mem_strb", 32'(mem_strb), 32'(m_strb));
      end
      chk(frame_req == m_freq, "R10 frame_req", 32'(frame_req), 32'(m_freq));
      chk(irq == (m_ie && !m_busy), "R9 irq", 32'(irq), 32'(m_ie && !m_busy));
    end
  end

  function automatic logic [31:0] ctrl_exp();
    return 32'h5440_0000 | (32'(m_pd) << 21) | (32'(m_strb) << 16) |
           (32'(m_vs) << 15) | (32'(m_ie) << 2) | (32'(m_busy) << 1);
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    step();
    reg_we = 0;
  endtask

  task automatic rd(logic [4:0] a, logic [31:0] exp, string tag);
    reg_addr = a;
    #2;
    chk(reg_rdata == exp, tag, reg_rdata, exp);
    step();
  endtask

  task automatic run(int n, bit dense);
    for (int i = 0; i < n; i++) begin
      pix_valid = dense ? 1'b1 : ($urandom_range(0, 3) != 0);
      mem_ready = dense ? 1'b1 : ($urandom_range(0, 3) != 0);
      pix_data  = $urandom;
      step();
    end
  endtask

  task automatic run_until_idle();
    for (int i = 0; i < 4000 && m_busy; i++) run(1, 0);
    pix_valid = 0;
    step();
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin : stim
    rst_n = 0; reg_we = 0; reg_addr = '0; reg_wdata = '0;
    pix_valid = 0; pix_data = '0; mem_ready = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) step();
    cmp_en = 1;

    rd(5'h0C, 32'h5440_0000, "R1 ctrl reset");
    rd(5'h10, 32'h0, "R1 progress reset");

    wr(5'h00, 32'h0001_0003);
    wr(5'h04, 32'h0000_004F);
    wr(5'h08, 32'h0003_0004);
    rd(5'h00, 32'h0001_0000, "R2 ptr");
    rd(5'h04, 32'h0000_0040, "R2 pitch");
    rd(5'h08, 32'h0003_0004, "R2 dim");

    wr(5'h0C, 32'h0020_0001);
    rd(5'h0C, 32'h5460_0000, "R4 start in power-down");

    wr(5'h0C, 32'h000F_8005);
    rd(5'h0C, 32'h544F_8006, "R3 busy set, start clear");
    run(5, 0);
    pix_valid = 0;
    wr(5'h0C, 32'h000F_8005);
    rd(5'h10, 32'(m_prog), "R4 start while busy");
    run_until_idle();
    rd(5'h10, 32'd3, "R7 progress equals height");
    rd(5'h0C, 32'h544F_8004, "R7 busy clear");
    chk(irq == 1'b1, "R9 irq when idle", 32'(irq), 32'd1);
    wr(5'h0C, 32'h000F_0000);
    #2 chk(irq == 1'b0, "R9 irq acknowledged", 32'(irq), 32'd0);

    wr(5'h00, 32'h2000_0000);
    wr(5'h04, 32'h0000_0020);
    wr(5'h08, 32'h0005_0002);
    wr(5'h0C, 32'h0005_0005);
    run_until_idle();
    rd(5'h10, 32'd5, "R6 progress after second frame");

    wr(5'h08, 32'h0006_0003);
    wr(5'h0C, 32'h000F_8005);
    run(8, 1);
    wr(5'h0C, 32'h0000_4004);
    rd(5'h0C, 32'h5440_0004, "R8 busy dropped on abort");
    run(4, 1);
    pix_valid = 0;
    rd(5'h10, 32'd2, "R8 progress held after abort");
    chk(irq == 1'b1, "R9 irq after abort", 32'(irq), 32'd1);

    wr(5'h08, 32'h0000_0007);
    wr(5'h0C, 32'h000F_0001);
    rd(5'h0C, 32'h544F_0000, "R4 start with zero height");
    rd(5'h10, 32'd2, "R4 progress untouched");

    wr(5'h08, 32'h0002_0005);
    wr(5'h04, 32'h0000_0100);
    wr(5'h0C, 32'h0003_8001);
    run_until_idle();
    rd(5'h10, 32'd2, "R6 progress third frame");

    repeat (3) step();
    summary();
  end
endmodule